// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block turns I/O-space accesses into physical request addresses for the memory system. Each access carries a 16-bit port number, a size code, a read/write flag and 32 bits of write data. One cycle later the block reports a target class and a physical address. The target is the internal configuration-address register, the PCI configuration space, or ordinary I/O space.

The block holds the 32-bit configuration-address register. Its top bit is kept as a two-state machine. In `CFG_IDLE` the configuration window is closed (bit 31 clear). In `CFG_ARMED` it is open (bit 31 set). The remaining 31 bits are kept as an offset field. There are two transitions, and both happen only on an accepted 4-byte write to the address port. `ARM` moves the machine to `CFG_ARMED` when write data bit 31 is 1. `DISARM` moves it to `CFG_IDLE` when that bit is 0. Every other cycle takes the `HOLD` transition, which keeps the current state.

An access to the data window is steered by this state. The result therefore depends on earlier writes and not on the port number alone.

Top module: `pcicfg_port_decoder`

## Requirements
- R1: After reset `resp_valid` is 0, the machine is in `CFG_IDLE` and the offset field is zero. A data-window access that follows reset, with no address-port write in between, goes to I/O space.
- R2: The size code `req_size` is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 is reserved. A read or write to port 0x0CF8 with size code 2 returns target `2'b10` (internal register) and physical address `REG_ADDR`.
- R3: An access to port 0x0CF8 with any size code other than 2 returns target `2'b00` (plain I/O) and address `IO_PREFIX | port`.
- R4: A write to port 0x0CF8 with size code 2 loads the register from `req_wdata`. The new value steers the very next access. Reads of 0x0CF8, writes of other sizes and writes to other ports leave the register unchanged.
- R5: In `CFG_ARMED`, an access to any port 0x0CFC to 0x0CFF returns target `2'b01` (PCI config). The match ignores port bits 1:0. The address is `CFG_PREFIX | ((offset + port[1:0]) mod 2^31)`, where offset is register bits 30:0.
- R6: In `CFG_IDLE`, an access to 0x0CFC to 0x0CFF returns target `2'b00` and address `IO_PREFIX | port`.
- R7: Any port outside 0x0CF8 and 0x0CFC to 0x0CFF returns target `2'b00` and address `IO_PREFIX | port`. All 16 port bits are kept.
- R8: `resp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. It is 0 otherwise. Cycles without a request leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_port | input | 16 | I/O port number |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=reserved |
| req_write | input | 1 | 1 for a write |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present this cycle |
| resp_target | output | 2 | 00 I/O, 01 PCI config, 10 internal register |
| resp_paddr | output | 40 | Physical request address |

## Verification
Two functions can fall in adjacent cycles with nothing between them: the register update from an address-port write, and the routing of a data-window access that depends on that update. The sweep issues accesses back to back over every port from 0x0CF0 to 0x0D0F, with every size code and both directions. Address-port writes therefore land directly before data-window accesses, with bit 31 both clear and set. The bench keeps its own copy of the register, updated in the same cycle as the write. Each routed target and address is compared against that copy, which shows whether the new value was used on the very next access. A carry test shows whether the offset-plus-low-bits sum wraps within 31 bits.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
    typedef enum logic [1:0] {
        TGT_IO     = 2'b00,
        TGT_PCICFG = 2'b01,
        TGT_REG    = 2'b10
    } target_e;

    typedef enum logic {
        CFG_IDLE  = 1'b0,
        CFG_ARMED = 1'b1
    } cfg_state_e;

    localparam logic [1:0] SZ_4B = 2'd2;
endpackage

// File: rtl/pcicfg_addr_reg.sv
module pcicfg_addr_reg
    import pcicfg_pkg::*;
#(
    parameter int              PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output cfg_state_e        cfg_state,
    output logic [30:0]       cfg_offset
);
    logic       load;
    cfg_state_e state_nxt;

    assign load = req_valid && req_write && (req_port == ADDR_PORT) && (req_size == SZ_4B);

    always_comb begin
        state_nxt = cfg_state;
        unique case (cfg_state)
            CFG_IDLE:  if (load && req_wdata[31])  state_nxt = CFG_ARMED;
            CFG_ARMED: if (load && !req_wdata[31]) state_nxt = CFG_IDLE;
            default:   state_nxt = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_state <= CFG_IDLE;
        else        cfg_state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_offset <= '0;
        else if (load) cfg_offset <= req_wdata[30:0];
    end

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_port == ADDR_PORT && req_size == SZ_4B)
        |=> ($stable(cfg_state) && $stable(cfg_offset)));
endmodule

// File: rtl/pcicfg_route.sv
module pcicfg_route
    import pcicfg_pkg::*;
#(
    parameter int                 PORT_W     = 16,
    parameter int                 PADDR_W    = 40,
    parameter logic [PORT_W-1:0]  ADDR_PORT  = 16'h0CF8,
    parameter logic [PORT_W-1:0]  DATA_PORT  = 16'h0CFC,
    parameter logic [PADDR_W-1:0] IO_PREFIX  = 40'h80_0000_0000,
    parameter logic [PADDR_W-1:0] CFG_PREFIX = 40'h40_0000_0000,
    parameter logic [PADDR_W-1:0] REG_ADDR   = 40'h00_0000_0C00
) (
    input  logic [PORT_W-1:0]  port,
    input  logic [1:0]         size,
    input  cfg_state_e         cfg_state,
    input  logic [30:0]        cfg_offset,
    output target_e            target,
    output logic [PADDR_W-1:0] paddr
);
    logic        hit_addr;
    logic        hit_data;
    logic [30:0] cfg_sum;

    assign hit_addr = (port == ADDR_PORT) && (size == SZ_4B);
    assign hit_data = (port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);
    assign cfg_sum  = cfg_offset + {29'd0, port[1:0]};

    always_comb begin
        target = TGT_IO;
        paddr  = IO_PREFIX | PADDR_W'(port);
        if (hit_addr) begin
            target = TGT_REG;
            paddr  = REG_ADDR;
        end else if (hit_data && cfg_state == CFG_ARMED) begin
            target = TGT_PCICFG;
            paddr  = CFG_PREFIX | PADDR_W'(cfg_sum);
        end
    end
endmodule

// File: rtl/pcicfg_port_decoder.sv
module pcicfg_port_decoder
    import pcicfg_pkg::*;
#(
    parameter int                 PORT_W     = 16,
    parameter int                 PADDR_W    = 40,
    parameter logic [PORT_W-1:0]  ADDR_PORT  = 16'h0CF8,
    parameter logic [PORT_W-1:0]  DATA_PORT  = 16'h0CFC,
    parameter logic [PADDR_W-1:0] IO_PREFIX  = 40'h80_0000_0000,
    parameter logic [PADDR_W-1:0] CFG_PREFIX = 40'h40_0000_0000,
    parameter logic [PADDR_W-1:0] REG_ADDR   = 40'h00_0000_0C00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [15:0]        req_port,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [31:0]        req_wdata,
    output logic               resp_valid,
    output logic [1:0]         resp_target,
    output logic [PADDR_W-1:0] resp_paddr
);
    localparam int TGT_W = $bits(target_e);

    cfg_state_e         cfg_state;
    logic [30:0]        cfg_offset;
    target_e            rt_target;
    logic [PADDR_W-1:0] rt_paddr;
    logic [PORT_W-1:0]  port_q;

    assign port_q = PORT_W'(req_port);

    pcicfg_addr_reg #(.PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT)) u_areg (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(port_q),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .cfg_state(cfg_state), .cfg_offset(cfg_offset)
    );

    pcicfg_route #(
        .PORT_W(PORT_W), .PADDR_W(PADDR_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT),
        .IO_PREFIX(IO_PREFIX), .CFG_PREFIX(CFG_PREFIX), .REG_ADDR(REG_ADDR)
    ) u_route (
        .port(port_q), .size(req_size), .cfg_state(cfg_state), .cfg_offset(cfg_offset),
        .target(rt_target), .paddr(rt_paddr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_target <= TGT_W'(TGT_IO);
            resp_paddr  <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_target <= rt_target;
                resp_paddr  <= rt_paddr;
            end
        end
    end

    // R8
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    // R8
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    // R2
    tgt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_target != 2'b11));
    // R7
    io_port_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid ##1 (resp_valid && resp_target == TGT_IO))
        |-> resp_paddr[PORT_W-1:0] == $past(port_q));
    // R5
    cfg_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_target == TGT_PCICFG) |-> ((resp_paddr & CFG_PREFIX) == CFG_PREFIX));
endmodule

// File: tb/pcicfg_port_decoder_bench.sv
module pcicfg_port_decoder_bench;
    localparam logic [39:0] IO_PFX  = 40'h80_0000_0000;
    localparam logic [39:0] CFG_PFX = 40'h40_0000_0000;
    localparam logic [39:0] REG_A   = 40'h00_0000_0C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_port = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [1:0]  resp_target;
    logic [39:0] resp_paddr;

    int errors = 0;
    int checks = 0;
    logic [31:0] model_cfg = 32'd0;

    always #2 clk = ~clk;

    pcicfg_port_decoder u_pcicfg_port_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_target(resp_target), .resp_paddr(resp_paddr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] p, input logic [1:0] sz, input logic wr,
                          input logic [31:0] d);
        logic [1:0]  et;
        logic [39:0] ea;
        logic [30:0] s;
        string       tag;
        @(negedge clk);
        req_valid = 1'b1; req_port = p; req_size = sz; req_write = wr; req_wdata = d;
        if (p == 16'h0CF8 && sz == 2'd2) begin
            et = 2'b10; ea = REG_A; tag = "R2";
        end else if (p == 16'h0CF8) begin
            et = 2'b00; ea = IO_PFX | {24'd0, p}; tag = "R3";
        end else if (p >= 16'h0CFC && p <= 16'h0CFF && model_cfg[31]) begin
            s  = model_cfg[30:0] + 31'(p - 16'h0CFC);
            et = 2'b01; ea = CFG_PFX | {9'd0, s}; tag = "R5";
        end else if (p >= 16'h0CFC && p <= 16'h0CFF) begin
            et = 2'b00; ea = IO_PFX | {24'd0, p}; tag = "R6";
        end else begin
            et = 2'b00; ea = IO_PFX | {24'd0, p}; tag = "R7";
        end
        @(posedge clk);
        if (wr && p == 16'h0CF8 && sz == 2'd2) model_cfg = d;
        #1;
        check("R8 resp_valid", {63'd0, resp_valid}, 64'd1);
        check({tag, " target (R4 state)"}, {62'd0, resp_target}, {62'd0, et});
        check({tag, " paddr (R4 state)"}, {24'd0, resp_paddr}, {24'd0, ea});
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_port = 16'h0CF8; req_size = 2'd2; req_write = 1'b1; req_wdata = 32'h1234_5678;
            @(posedge clk); #1;
            check("R8 idle resp_valid", {63'd0, resp_valid}, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset resp_valid", {63'd0, resp_valid}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        access(16'h0CFC, 2'd2, 1'b0, 32'd0);   // R1: window closed after reset
        access(16'h0CFF, 2'd0, 1'b0, 32'd0);
        for (int pass = 0; pass < 2; pass++) begin
            for (int p = 16'h0CF0; p <= 16'h0D0F; p++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        access(16'(p), 2'(sz), wr[0],
                               {pass[0], 31'(p * 32'h0001_0203 + sz * 32'h100)});
                        if (p == 16'h0CF8 && wr == 1)
                            access(16'h0CFD, 2'd1, 1'b0, 32'd0); // back-to-back R4
                    end
                end
            end
        end
        for (int b = 0; b < 16; b++) begin
            access(16'(1 << b), 2'd2, 1'b0, 32'd0);            // R7
            access(16'h0CF8 ^ 16'(1 << b), 2'd2, 1'b1, 32'hFFFF_FFFF);
        end
        access(16'hFFFF, 2'd1, 1'b0, 32'd0);
        access(16'h0000, 2'd0, 1'b1, 32'd0);
        access(16'h0CF8, 2'd2, 1'b1, 32'hFFFF_FFFF);          // R5 wrap
        access(16'h0CFF, 2'd0, 1'b0, 32'd0);
        access(16'h0CF8, 2'd2, 1'b0, 32'h0000_0000);          // R4 read keeps
        access(16'h0CFE, 2'd0, 1'b1, 32'd0);
        idle(3);                                               // R8 idle keeps
        access(16'h0CFC, 2'd2, 1'b0, 32'd0);
        access(16'h0CF8, 2'd2, 1'b1, 32'h0000_0040);          // R6 disarm
        access(16'h0CFC, 2'd2, 1'b0, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule